// File: doc/BRIEF.md
# Dual-Clock FIFO with Block Replay

This block is a first-in first-out buffer of 256 words of 36 bits. Its write side and its read side each run on their own clock, and the two clocks may have any frequency and phase relation. Nothing happens at a side unless that side's enable and request are both high at a rising edge of its clock. An acknowledge output then reports, for one cycle, whether the transfer took place. A write into a full buffer and a read from an empty one are refused, and no state changes.

The buffer reports its fill level through five flags. Full, almost-full and half-full belong to the write clock. Empty and almost-empty belong to the read clock. The almost-full and almost-empty distances can each be loaded through a one-cycle load strobe on their own side. After reset both distances are 8, so the block works without any programming.

A mark strobe on the read side records the current read position. A replay strobe returns the read position to that mark, so the same block of words can be read again as many times as needed. Once a mark exists, the writer is not given back any location at or after the mark. Marking again at a later position releases the words before the new mark. Pointers cross between the clocks as Gray codes through two-flop synchronizers.

Top module: `dcf_retx_fifo`

## Requirements
- R1: After reset, empty and almost_empty are 1, and full, almost_full, half_full, wr_ack and rd_ack are 0.
- R2: A write is accepted at a wr_clk rising edge exactly when wr_en and wr_req are both 1 and full is 0. wr_ack is 1 during the following wr_clk cycle only for an accepted write. A write attempt with wr_req at 0 stores nothing.
- R3: A write attempted while full gets wr_ack 0 and leaves every stored word unchanged.
- R4: A read is accepted at an rd_clk rising edge exactly when rd_en and rd_req are both 1, empty is 0 and replay is 0. In the following rd_clk cycle, rd_ack is 1 and rd_data holds the oldest unread word, in write order. A read attempted while empty gets rd_ack 0.
- R5: full is 1 exactly when 256 words are held. half_full is 1 when at least 129 words are held.
- R6: almost_full is 1 when the occupancy seen by the writer is at least 256 minus the almost-full distance. The distance is 8 after reset. It is loaded from af_value on a wr_clk edge with af_load at 1, and values above 256 are clamped to 256.
- R7: almost_empty is 1 when the occupancy seen by the reader is at most the almost-empty distance. The distance is 8 after reset. It is loaded from ae_value on an rd_clk edge with ae_load at 1, and values above 256 are clamped to 256.
- R8: A mark pulse on an rd_clk edge records the read position before any read at that edge. A replay pulse with a recorded mark returns the read position to the mark, and later reads repeat the words from the mark onward. A read requested at the same edge as replay is refused.
- R9: Once a mark exists, the writer counts occupancy from the mark rather than from the read position. Reading past the mark therefore frees no space. A new mark at a later position frees the words before it.
- R10: Flags on the side opposite a pointer change follow that change within a bounded number of cycles of their own clock, because each pointer crosses the clocks through two synchronizing flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write enable |
| wr_req | input | 1 | Write request |
| wr_data | input | 36 | Word to store |
| wr_ack | output | 1 | Write accepted at the previous wr_clk edge |
| af_load | input | 1 | Load strobe for the almost-full distance |
| af_value | input | 9 | New almost-full distance |
| full | output | 1 | 256 words held |
| almost_full | output | 1 | Near full by the programmed distance |
| half_full | output | 1 | At least 129 words held |
| rd_clk | input | 1 | Read-side clock |
| rd_en | input | 1 | Read enable |
| rd_req | input | 1 | Read request |
| rd_data | output | 36 | Word read at the previous accepted read |
| rd_ack | output | 1 | Read accepted at the previous rd_clk edge |
| mark | input | 1 | Record the current read position |
| replay | input | 1 | Return the read position to the mark |
| ae_load | input | 1 | Load strobe for the almost-empty distance |
| ae_value | input | 9 | New almost-empty distance |
| empty | output | 1 | No unread word seen by the reader |
| almost_empty | output | 1 | Near empty by the programmed distance |

## Verification
The bench walks the fill level across every flag edge, one word on each side of it: 8 and 9 words for almost-empty, 128 and 129 for half-full, 247 and 248 for almost-full, and 255 and 256 for full. An off-by-one compare would move a flag one word early or late. It then writes into a full buffer and reads all 256 words back in order. A design that lets the write pointer run past the read pointer would overwrite the oldest word or report a ghost entry. In the replay test, a read is requested at the same edge as the replay, and the block after the mark is read back. It then fills until the writer is refused: a design that freed space past the mark would accept more than 246 further words and overwrite the block it must replay.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  localparam int unsigned FW = 16;
  typedef logic [FW-1:0] ptr_t;

  function automatic ptr_t to_gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t from_gray(ptr_t g);
    ptr_t b;
    b[FW-1] = g[FW-1];
    for (int i = FW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // distance from lag to lead, modulo 2**pw
  function automatic ptr_t ptr_dist(ptr_t lead, ptr_t lag, int unsigned pw);
    ptr_t m;
    m = (ptr_t'(1) << pw) - ptr_t'(1);
    return (lead - lag) & m;
  endfunction
endpackage

// File: rtl/dcf_sync2.sv
`timescale 1ns/1ps
module dcf_sync2 #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 36
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int unsigned AW      = 8,
  parameter int unsigned THR_DEF = 8,
  localparam int unsigned PW     = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_req,
  input  logic          af_load,
  input  logic [PW-1:0] af_value,
  input  logic [PW-1:0] free_gray_s,
  output logic          wr_fire,
  output logic [AW-1:0] wr_addr,
  output logic [PW-1:0] wr_gray,
  output logic          wr_ack,
  output logic [PW-1:0] wr_occ,
  output logic          full,
  output logic          almost_full,
  output logic          half_full
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned HALF  = DEPTH / 2 + 1;

  logic [PW-1:0] wptr, thr;
  ptr_t          free_bin, occ_w, nxt_gray;

  always_comb begin
    free_bin    = from_gray(ptr_t'(free_gray_s));
    occ_w       = ptr_dist(ptr_t'(wptr), free_bin, PW);
    wr_occ      = occ_w[PW-1:0];
    full        = (wr_occ == PW'(DEPTH));
    almost_full = (wr_occ >= PW'(DEPTH) - thr);
    half_full   = (wr_occ >= PW'(HALF));
    wr_fire     = wr_en && wr_req && !full;
    wr_addr     = wptr[AW-1:0];
    nxt_gray    = to_gray(ptr_t'(wptr + 1'b1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      wr_gray <= '0;
      wr_ack  <= 1'b0;
      thr     <= PW'(THR_DEF);
    end else begin
      wr_ack <= wr_fire;
      if (wr_fire) begin
        wptr    <= wptr + 1'b1;
        wr_gray <= nxt_gray[PW-1:0];
      end
      if (af_load) thr <= (af_value > PW'(DEPTH)) ? PW'(DEPTH) : af_value;
    end
  end
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int unsigned AW      = 8,
  parameter int unsigned THR_DEF = 8,
  localparam int unsigned PW     = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          rd_req,
  input  logic          mark,
  input  logic          replay,
  input  logic          ae_load,
  input  logic [PW-1:0] ae_value,
  input  logic [PW-1:0] wr_gray_s,
  output logic          rd_fire,
  output logic [AW-1:0] rd_addr,
  output logic [PW-1:0] free_gray,
  output logic          rd_ack,
  output logic [PW-1:0] rd_occ,
  output logic          empty,
  output logic          almost_empty
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [PW-1:0] rptr, mark_ptr, free_ptr, thr, target;
  logic          mark_vld;
  ptr_t          wr_bin, occ_r, nxt_gray;

  always_comb begin
    wr_bin       = from_gray(ptr_t'(wr_gray_s));
    occ_r        = ptr_dist(wr_bin, ptr_t'(rptr), PW);
    rd_occ       = occ_r[PW-1:0];
    empty        = (rd_occ == '0);
    almost_empty = (rd_occ <= thr);
    rd_fire      = rd_en && rd_req && !empty && !replay;
    rd_addr      = rptr[AW-1:0];
    // the writer may reuse only what lies before this position
    target       = mark_vld ? mark_ptr : rptr;
    nxt_gray     = to_gray(ptr_t'(free_ptr + 1'b1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr      <= '0;
      mark_ptr  <= '0;
      mark_vld  <= 1'b0;
      free_ptr  <= '0;
      free_gray <= '0;
      rd_ack    <= 1'b0;
      thr       <= PW'(THR_DEF);
    end else begin
      rd_ack <= rd_fire;
      if (replay && mark_vld) rptr <= mark_ptr;
      else if (rd_fire)       rptr <= rptr + 1'b1;
      if (mark) begin
        mark_ptr <= rptr;
        mark_vld <= 1'b1;
      end
      // one step per cycle keeps the crossing code single-bit
      if (free_ptr != target) begin
        free_ptr  <= free_ptr + 1'b1;
        free_gray <= nxt_gray[PW-1:0];
      end
      if (ae_load) thr <= (ae_value > PW'(DEPTH)) ? PW'(DEPTH) : ae_value;
    end
  end
endmodule

// File: rtl/dcf_retx_fifo.sv
`timescale 1ns/1ps
module dcf_retx_fifo #(
  parameter int unsigned AW     = 8,
  parameter int unsigned DW     = 36,
  parameter int unsigned AF_DEF = 8,
  parameter int unsigned AE_DEF = 8,
  localparam int unsigned PW    = AW + 1
) (
  input  logic          rst_n,
  input  logic          wr_clk,
  input  logic          wr_en,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ack,
  input  logic          af_load,
  input  logic [PW-1:0] af_value,
  output logic          full,
  output logic          almost_full,
  output logic          half_full,
  input  logic          rd_clk,
  input  logic          rd_en,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  output logic          rd_ack,
  input  logic          mark,
  input  logic          replay,
  input  logic          ae_load,
  input  logic [PW-1:0] ae_value,
  output logic          empty,
  output logic          almost_empty
);
  logic          wr_fire, rd_fire;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [PW-1:0] wr_gray, wr_gray_s, free_gray, free_gray_s;
  logic [PW-1:0] wr_occ, rd_occ;

  dcf_wr_side #(.AW(AW), .THR_DEF(AF_DEF)) wr_side_i (
    .clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_req(wr_req),
    .af_load(af_load), .af_value(af_value), .free_gray_s(free_gray_s),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_gray(wr_gray), .wr_ack(wr_ack),
    .wr_occ(wr_occ), .full(full), .almost_full(almost_full), .half_full(half_full)
  );

  dcf_rd_side #(.AW(AW), .THR_DEF(AE_DEF)) rd_side_i (
    .clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en), .rd_req(rd_req),
    .mark(mark), .replay(replay), .ae_load(ae_load), .ae_value(ae_value),
    .wr_gray_s(wr_gray_s), .rd_fire(rd_fire), .rd_addr(rd_addr),
    .free_gray(free_gray), .rd_ack(rd_ack), .rd_occ(rd_occ),
    .empty(empty), .almost_empty(almost_empty)
  );

  dcf_sync2 #(.W(PW)) wsync_i (.clk(rd_clk), .rst_n(rst_n), .d(wr_gray),   .q(wr_gray_s));
  dcf_sync2 #(.W(PW)) fsync_i (.clk(wr_clk), .rst_n(rst_n), .d(free_gray), .q(free_gray_s));

  dcf_ram #(.AW(AW), .DW(DW)) ram_i (
    .wclk(wr_clk), .we(wr_fire), .waddr(wr_addr), .wdata(wr_data),
    .rclk(rd_clk), .re(rd_fire), .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/dcf_retx_fifo_chk.sv
`timescale 1ns/1ps
module dcf_retx_fifo_chk #(
  parameter int unsigned PW = 9
) (
  input logic          rst_n,
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wr_en,
  input logic          wr_req,
  input logic          wr_fire,
  input logic          wr_ack,
  input logic          rd_en,
  input logic          rd_req,
  input logic          rd_ack,
  input logic          replay,
  input logic          full,
  input logic          almost_full,
  input logic          half_full,
  input logic          empty,
  input logic          almost_empty,
  input logic [PW-1:0] wr_occ,
  input logic [PW-1:0] rd_occ
);
  localparam int unsigned DEPTH = 1 << (PW - 1);

  // R3: refused at full
  a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (full && wr_en && wr_req) |=> !wr_ack);
  // R2: accepted write is acknowledged
  a_r2_ack_follows_fire: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_fire |=> wr_ack);
  // R2: no acknowledge without request
  a_r2_no_spurious_ack: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !(wr_en && wr_req) |=> !wr_ack);
  // R4: refused at empty
  a_r4_no_underflow: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (empty && rd_en && rd_req) |=> !rd_ack);
  // R8: replay wins over a read at the same edge
  a_r8_replay_blocks_read: assert property (@(posedge rd_clk) disable iff (!rst_n)
    replay |=> !rd_ack);
  // R5: occupancy stays within depth and full implies the lower flags
  a_r5_occ_bounded: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_occ <= PW'(DEPTH));
  a_r5_full_nested: assert property (@(posedge wr_clk) disable iff (!rst_n)
    full |-> (almost_full && half_full));
  // R7: empty implies almost empty, reader never sees more than depth
  a_r7_empty_nested: assert property (@(posedge rd_clk) disable iff (!rst_n)
    empty |-> almost_empty);
  a_r7_rd_occ_bounded: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_occ <= PW'(DEPTH));
endmodule

bind dcf_retx_fifo dcf_retx_fifo_chk #(.PW(PW)) chk_i (.*);

// File: tb/dcf_retx_fifo_tb_top.sv
`timescale 1ns/1ps
module dcf_retx_fifo_tb_top;
  localparam int DW = 36;
  localparam int PW = 9;

  logic rst_n = 1'b0;
  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_en = 0, wr_req = 0, af_load = 0;
  logic [DW-1:0] wr_data = '0;
  logic [PW-1:0] af_value = '0, ae_value = '0;
  logic rd_en = 0, rd_req = 0, mark = 0, replay = 0, ae_load = 0;
  logic wr_ack, full, almost_full, half_full, rd_ack, empty, almost_empty;
  logic [DW-1:0] rd_data;

  int n_tests = 0, n_fail = 0;
  int wr_idx = 0, rd_idx = 0;
  bit done = 0;

  always #10 wr_clk = ~wr_clk;   // 50 MHz
  always #13 rd_clk = ~rd_clk;

  dcf_retx_fifo dut_i (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_req(wr_req), .wr_data(wr_data),
    .wr_ack(wr_ack), .af_load(af_load), .af_value(af_value), .full(full),
    .almost_full(almost_full), .half_full(half_full), .rd_clk(rd_clk), .rd_en(rd_en),
    .rd_req(rd_req), .rd_data(rd_data), .rd_ack(rd_ack), .mark(mark), .replay(replay),
    .ae_load(ae_load), .ae_value(ae_value), .empty(empty), .almost_empty(almost_empty)
  );

  function automatic logic [DW-1:0] pat(int i);
    return {4'h5, 32'(i) * 32'h9E3779B1};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge wr_clk);
    repeat (n) @(posedge rd_clk);
    @(negedge rd_clk);
  endtask

  task automatic do_write(input bit req, output bit acked);
    @(negedge wr_clk);
    wr_en = 1; wr_req = req; wr_data = pat(wr_idx);
    @(negedge wr_clk);
    wr_en = 0; wr_req = 0;
    acked = wr_ack;
    if (acked) wr_idx++;
  endtask

  task automatic do_read(output bit acked, output logic [DW-1:0] d);
    @(negedge rd_clk);
    rd_en = 1; rd_req = 1;
    @(negedge rd_clk);
    rd_en = 0; rd_req = 0;
    acked = rd_ack; d = rd_data;
  endtask

  task automatic read_expect(input int cnt, input string tag);
    bit a; logic [DW-1:0] d;
    for (int i = 0; i < cnt; i++) begin
      do_read(a, d);
      if (!a || d !== pat(rd_idx)) begin
        chk(a, {tag, " read ack"}, 64'(a), 64'd1);
        chk(d === pat(rd_idx), {tag, " read data"}, 64'(d), 64'(pat(rd_idx)));
      end
      rd_idx++;
    end
    chk(1'b1, {tag, " read block"}, 0, 0);
  endtask

  task automatic t_reset;
    chk(empty === 1'b1, "R1 empty", 64'(empty), 1);
    chk(almost_empty === 1'b1, "R1 almost_empty", 64'(almost_empty), 1);
    chk({full, almost_full, half_full} === 3'b000, "R1 write flags", 64'({full, almost_full, half_full}), 0);
    chk({wr_ack, rd_ack} === 2'b00, "R1 acks", 64'({wr_ack, rd_ack}), 0);
  endtask

  task automatic t_basic;
    bit a; logic [DW-1:0] d;
    do_write(1'b0, a);
    chk(a === 1'b0, "R2 no request no ack", 64'(a), 0);
    settle(6);
    chk(empty === 1'b1, "R2 no request stores nothing", 64'(empty), 1);
    for (int i = 0; i < 3; i++) begin
      do_write(1'b1, a);
      chk(a === 1'b1, "R2 write ack", 64'(a), 1);
    end
    settle(6);
    chk(empty === 1'b0, "R10 empty clears after crossing", 64'(empty), 0);
    read_expect(3, "R4");
    do_read(a, d);
    chk(a === 1'b0, "R4 read at empty refused", 64'(a), 0);
  endtask

  task automatic t_fill;
    bit a;
    for (int i = 1; i <= 256; i++) begin
      do_write(1'b1, a);
      if (!a) chk(a, "R2 fill ack", 64'(a), 1);
      case (i)
        8:   begin settle(6); chk(almost_empty === 1'b1, "R7 ae at 8", 64'(almost_empty), 1); end
        9:   begin settle(6); chk(almost_empty === 1'b0, "R7 ae at 9", 64'(almost_empty), 0); end
        128: begin settle(6); chk(half_full === 1'b0, "R5 hf at 128", 64'(half_full), 0); end
        129: begin settle(6); chk(half_full === 1'b1, "R5 hf at 129", 64'(half_full), 1); end
        247: begin settle(6); chk(almost_full === 1'b0, "R6 af at 247", 64'(almost_full), 0); end
        248: begin settle(6); chk(almost_full === 1'b1, "R6 af at 248", 64'(almost_full), 1); end
        255: begin settle(6); chk(full === 1'b0, "R5 full at 255", 64'(full), 0); end
        256: begin settle(6); chk(full === 1'b1, "R5 full at 256", 64'(full), 1); end
        default: ;
      endcase
    end
    do_write(1'b1, a);
    chk(a === 1'b0, "R3 write at full refused", 64'(a), 0);
    read_expect(256, "R3");
    settle(6);
    chk(empty === 1'b1 && full === 1'b0, "R4 drained", 64'({empty, full}), 64'(2'b10));
  endtask

  task automatic t_prog;
    bit a;
    @(negedge wr_clk); af_load = 1; af_value = 9'd16;
    @(negedge wr_clk); af_load = 0;
    @(negedge rd_clk); ae_load = 1; ae_value = 9'd4;
    @(negedge rd_clk); ae_load = 0;
    for (int i = 1; i <= 240; i++) begin
      do_write(1'b1, a);
      case (i)
        4:   begin settle(6); chk(almost_empty === 1'b1, "R7 prog ae at 4", 64'(almost_empty), 1); end
        5:   begin settle(6); chk(almost_empty === 1'b0, "R7 prog ae at 5", 64'(almost_empty), 0); end
        239: begin settle(6); chk(almost_full === 1'b0, "R6 prog af at 239", 64'(almost_full), 0); end
        240: begin settle(6); chk(almost_full === 1'b1, "R6 prog af at 240", 64'(almost_full), 1); end
        default: ;
      endcase
    end
    read_expect(240, "R6");
  endtask

  task automatic t_replay;
    bit a; logic [DW-1:0] d; int base; int accepted;
    for (int i = 0; i < 10; i++) do_write(1'b1, a);
    settle(6);
    base = rd_idx;
    @(negedge rd_clk); mark = 1;
    @(negedge rd_clk); mark = 0;
    read_expect(5, "R8 first pass");
    @(negedge rd_clk); replay = 1; rd_en = 1; rd_req = 1;
    @(negedge rd_clk); replay = 0; rd_en = 0; rd_req = 0;
    chk(rd_ack === 1'b0, "R8 read refused at replay edge", 64'(rd_ack), 0);
    rd_idx = base;
    read_expect(10, "R8 replay pass");
    do_read(a, d);
    chk(a === 1'b0, "R8 empty after replay block", 64'(a), 0);
    settle(8);
    accepted = 0;
    for (int i = 0; i < 260; i++) begin
      do_write(1'b1, a);
      if (!a) break;
      accepted++;
    end
    chk(accepted == 246, "R9 space after mark held", 64'(accepted), 246);
    @(negedge rd_clk); mark = 1;
    @(negedge rd_clk); mark = 0;
    settle(20);
    chk(full === 1'b0, "R9 new mark frees space", 64'(full), 0);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge wr_clk);
    rst_n = 1'b1;
    settle(2);
    t_reset();
    t_basic();
    t_fill();
    t_prog();
    t_replay();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule